// File: doc/BRIEF.md
# Segment Selection and Linear Address Unit

This unit turns a memory access request into a linear address. It holds six segment registers. Each one has a visible 16-bit selector and a hidden base and limit. For every access it picks one segment, either by a default rule driven by the kind of access or by an explicit override. It then forms the linear address in the way the current operating mode requires: real, protected or 64-bit.

The segment registers are loaded through one write port. That port has a privilege qualifier. An ordinary load aimed at the code segment is refused and raises an illegal-operation fault. A privileged load, as made by a control-transfer path, may change the code segment.

Results are registered, so each access gives its address and its limit fault together one cycle later. With paging off, the address can be used directly as the physical address.

Top module: `seg_addr_unit`

## Requirements
- R1: While reset is held and after it is released, `out_vld`, `lim_fault` and `ill_fault` are 0 and `lin_addr` is 0. Every selector and base resets to 0 and every limit resets to 0xFFFF.
- R2: An access with `acc_kind` 0 (instruction fetch) always uses the code segment (id 1), whatever the override inputs say.
- R3: With no usable override, the default segment depends on `acc_kind`. Kind 1 (stack-relative or push/pop) uses the stack segment, id 2. Kind 2 (string destination) uses id 0. Kind 3 (other data) uses id 3. The segment ids are 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS, and the id used is shown on `out_seg`.
- R4: For non-fetch kinds, an override with `ovr_valid`=1 and `ovr_seg` in 0..5 replaces the default. Override codes 6 and 7 are ignored, and the default is kept.
- R5: In real mode (`mode`=0) the address is (selector*16 + `offset[15:0]`) mod 2^20. The hidden base is not used, upper offset bits are ignored, and no limit fault is raised.
- R6: In protected mode (`mode`=1) the address is (base[31:0] + `offset[31:0]`) mod 2^32, and its upper bits are 0.
- R7: In protected mode, `lim_fault` is 1 in the same cycle as the address exactly when `offset[31:0]` is greater than the selected segment's limit. An offset equal to the limit raises no fault.
- R8: In 64-bit mode (`mode` 2 or 3), ids 0–3 give an address equal to the full 64-bit offset. FS and GS give (base + offset) mod 2^64. No limit fault is raised.
- R9: A load with `ld_priv`=0 aimed at id 1 leaves the code segment unchanged and sets `ill_fault` for one cycle, on the cycle after the load. A privileged load of id 1 and any load of ids 0, 2–5 update the selector, base and limit. Loads to ids 6–7 change nothing.
- R10: Outputs appear one clock after `acc_valid`. `out_vld` is 0 after a cycle with no access, and `lin_addr` then holds its last value.
- R11: An access in the same cycle as a load of its segment uses the segment values from before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Segment load strobe |
| ld_priv | input | 1 | Load is privileged (may target the code segment) |
| ld_seg | input | 3 | Segment id to load |
| ld_sel | input | 16 | Selector value |
| ld_base | input | 64 | Hidden base value |
| ld_limit | input | 32 | Hidden limit value |
| acc_valid | input | 1 | Access request present |
| acc_kind | input | 2 | 0 fetch, 1 stack, 2 string destination, 3 data |
| ovr_valid | input | 1 | Explicit segment override present |
| ovr_seg | input | 3 | Override segment id |
| mode | input | 2 | 0 real, 1 protected, 2/3 64-bit |
| offset | input | 64 | Effective offset |
| out_vld | output | 1 | Registered result valid |
| lin_addr | output | 64 | Linear address |
| out_seg | output | 3 | Segment id used |
| lim_fault | output | 1 | Protected-mode limit violation |
| ill_fault | output | 1 | Refused code-segment load |

## Verification
The hardest case to reach from the ports is a load and an access to the same segment in the same cycle, together with limit comparisons exactly at the boundary. The bench issues a data access in the very cycle that reloads the data segment, and expects the old base. The next access must then show the new base. Protected accesses are placed at limit and limit+1, and wrapping sums are forced in real, protected and 64-bit modes. A refused code-segment load is followed by a fetch that proves the selector kept its old value.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int NUM_SEG  = 6;
  localparam int SEG_IDW  = 3;
  localparam int RM_W     = 20;
  localparam int RM_SHIFT = 4;
  localparam int RM_OFS_W = 16;
  localparam int PM_W     = 32;

  typedef enum logic [SEG_IDW-1:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_STACK  = 2'd1,
    ACC_STRDST = 2'd2,
    ACC_DATA   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    MODE_REAL  = 2'd0,
    MODE_PROT  = 2'd1,
    MODE_LONG  = 2'd2,
    MODE_LONG2 = 2'd3
  } cpu_mode_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int VA_W  = 64,
  parameter int LIM_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ld_en,
  input  logic                             ld_priv,
  input  logic [SEG_IDW-1:0]               ld_seg,
  input  logic [SEL_W-1:0]                 ld_sel,
  input  logic [VA_W-1:0]                  ld_base,
  input  logic [LIM_W-1:0]                 ld_limit,
  output logic [NUM_SEG-1:0][SEL_W-1:0]    sel_o,
  output logic [NUM_SEG-1:0][VA_W-1:0]     base_o,
  output logic [NUM_SEG-1:0][LIM_W-1:0]    limit_o,
  output logic                             ill_o
);
  localparam logic [LIM_W-1:0] LIM_RST = LIM_W'(32'h0000_FFFF);

  logic ill_d, ill_q;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam bit IS_CODE = (g == int'(SEG_CS));
    logic             we;
    logic [SEL_W-1:0] sel_d, sel_q;
    logic [VA_W-1:0]  base_d, base_q;
    logic [LIM_W-1:0] lim_d, lim_q;

    always_comb begin
      we     = ld_en && (ld_seg == SEG_IDW'(g)) && (!IS_CODE || ld_priv);
      sel_d  = sel_q;
      base_d = base_q;
      lim_d  = lim_q;
      if (we) begin
        sel_d  = ld_sel;
        base_d = ld_base;
        lim_d  = ld_limit;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q  <= '0;
        base_q <= '0;
        lim_q  <= LIM_RST;
      end else if (we) begin
        sel_q  <= sel_d;
        base_q <= base_d;
        lim_q  <= lim_d;
      end
    end

    assign sel_o[g]   = sel_q;
    assign base_o[g]  = base_q;
    assign limit_o[g] = lim_q;
  end

  always_comb begin
    ill_d = ld_en && !ld_priv && (ld_seg == SEG_CS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ill_q <= 1'b0;
    else        ill_q <= ill_d;
  end

  assign ill_o = ill_q;
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  logic [1:0]         kind,
  input  logic               ovr_valid,
  input  logic [SEG_IDW-1:0] ovr_seg,
  output logic [SEG_IDW-1:0] seg_id
);
  logic      ovr_ok;
  acc_kind_e kind_e;

  always_comb begin
    kind_e = acc_kind_e'(kind);
    ovr_ok = ovr_valid && (int'(ovr_seg) < NUM_SEG);
    unique case (kind_e)
      ACC_FETCH:  seg_id = SEG_CS;
      ACC_STACK:  seg_id = ovr_ok ? ovr_seg : SEG_SS;
      ACC_STRDST: seg_id = ovr_ok ? ovr_seg : SEG_ES;
      default:    seg_id = ovr_ok ? ovr_seg : SEG_DS;
    endcase
  end
endmodule

// File: rtl/addr_form.sv
module addr_form
  import seg_addr_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int VA_W  = 64,
  parameter int LIM_W = 32
) (
  input  logic [1:0]         mode,
  input  logic [SEG_IDW-1:0] seg_id,
  input  logic [SEL_W-1:0]   sel,
  input  logic [VA_W-1:0]    base,
  input  logic [LIM_W-1:0]   limit,
  input  logic [VA_W-1:0]    offset,
  output logic [VA_W-1:0]    lin,
  output logic               lim_hit
);
  logic [RM_W-1:0] rm_seg, rm_ofs, rm_sum;
  logic [PM_W-1:0] pm_sum;
  logic [VA_W-1:0] lm_sum;
  logic            lm_keep_base;
  cpu_mode_e       mode_e;

  always_comb begin
    mode_e       = cpu_mode_e'(mode);
    rm_seg       = RM_W'({sel, {RM_SHIFT{1'b0}}});
    rm_ofs       = RM_W'(offset[RM_OFS_W-1:0]);
    rm_sum       = rm_seg + rm_ofs;
    pm_sum       = base[PM_W-1:0] + offset[PM_W-1:0];
    lm_keep_base = (seg_id == SEG_FS) || (seg_id == SEG_GS);
    lm_sum       = lm_keep_base ? (base + offset) : offset;
    lin          = '0;
    lim_hit      = 1'b0;
    unique case (mode_e)
      MODE_REAL: lin = VA_W'(rm_sum);
      MODE_PROT: begin
        lin     = VA_W'(pm_sum);
        lim_hit = offset[PM_W-1:0] > PM_W'(limit);
      end
      default:   lin = lm_sum;
    endcase
  end
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_addr_pkg::*;
#(
  parameter int SEL_W = 16,
  parameter int VA_W  = 64,
  parameter int LIM_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic               ld_priv,
  input  logic [2:0]         ld_seg,
  input  logic [SEL_W-1:0]   ld_sel,
  input  logic [VA_W-1:0]    ld_base,
  input  logic [LIM_W-1:0]   ld_limit,
  input  logic               acc_valid,
  input  logic [1:0]         acc_kind,
  input  logic               ovr_valid,
  input  logic [2:0]         ovr_seg,
  input  logic [1:0]         mode,
  input  logic [VA_W-1:0]    offset,
  output logic               out_vld,
  output logic [VA_W-1:0]    lin_addr,
  output logic [2:0]         out_seg,
  output logic               lim_fault,
  output logic               ill_fault
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [NUM_SEG-1:0][SEL_W-1:0] sel_arr;
  logic [NUM_SEG-1:0][VA_W-1:0]  base_arr;
  logic [NUM_SEG-1:0][LIM_W-1:0] lim_arr;
  logic [SEG_IDW-1:0]            seg_id;
  logic [SEL_W-1:0]              sel_m;
  logic [VA_W-1:0]               base_m;
  logic [LIM_W-1:0]              lim_m;
  logic [VA_W-1:0]               lin_c;
  logic                          hit_c;

  seg_regfile #(.SEL_W(SEL_W), .VA_W(VA_W), .LIM_W(LIM_W)) u_regs (
    .clk(clk), .rst_n(rst_sync), .ld_en(ld_en), .ld_priv(ld_priv),
    .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_base(ld_base), .ld_limit(ld_limit),
    .sel_o(sel_arr), .base_o(base_arr), .limit_o(lim_arr), .ill_o(ill_fault)
  );

  seg_select u_sel (
    .kind(acc_kind), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg), .seg_id(seg_id)
  );

  always_comb begin
    sel_m  = '0;
    base_m = '0;
    lim_m  = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (seg_id == SEG_IDW'(i)) begin
        sel_m  = sel_arr[i];
        base_m = base_arr[i];
        lim_m  = lim_arr[i];
      end
    end
  end

  addr_form #(.SEL_W(SEL_W), .VA_W(VA_W), .LIM_W(LIM_W)) u_form (
    .mode(mode), .seg_id(seg_id), .sel(sel_m), .base(base_m), .limit(lim_m),
    .offset(offset), .lin(lin_c), .lim_hit(hit_c)
  );

  logic            vld_d, vld_q, flt_d, flt_q;
  logic [VA_W-1:0] lin_q;
  logic [2:0]      seg_q;

  always_comb begin
    vld_d = acc_valid;
    flt_d = acc_valid && hit_c;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      vld_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      flt_q <= flt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      lin_q <= '0;
      seg_q <= '0;
    end else if (acc_valid) begin
      lin_q <= lin_c;
      seg_q <= seg_id;
    end
  end

  assign out_vld   = vld_q;
  assign lin_addr  = lin_q;
  assign out_seg   = seg_q;
  assign lim_fault = flt_q;
endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk #(
  parameter int VA_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ld_en,
  input logic            ld_priv,
  input logic [2:0]      ld_seg,
  input logic            acc_valid,
  input logic [1:0]      acc_kind,
  input logic [1:0]      mode,
  input logic [VA_W-1:0] offset,
  input logic            out_vld,
  input logic [VA_W-1:0] lin_addr,
  input logic [2:0]      out_seg,
  input logic            lim_fault,
  input logic            ill_fault
);
  logic [1:0] live_cnt;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             live_cnt <= 2'd0;
    else if (live_cnt != 3) live_cnt <= live_cnt + 2'd1;
  end
  assign live = (live_cnt == 2'd3);

  AST_FETCH_USES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    live && acc_valid && acc_kind == 2'd0 |=> out_seg == 3'd1); // R2
  AST_REAL_20BIT: assert property (@(posedge clk) disable iff (!rst_n)
    live && acc_valid && mode == 2'd0 |=> lin_addr[VA_W-1:20] == '0 && !lim_fault); // R5
  AST_PROT_32BIT: assert property (@(posedge clk) disable iff (!rst_n)
    live && acc_valid && mode == 2'd1 |=> lin_addr[VA_W-1:32] == '0); // R6
  AST_LONG_FLAT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    live && acc_valid && mode[1] && acc_kind == 2'd0 |=> lin_addr == $past(offset) && !lim_fault); // R8
  AST_CODE_LOAD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    live && ld_en && !ld_priv && ld_seg == 3'd1 |=> ill_fault); // R9
  AST_NO_SPURIOUS_ILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_en && !ld_priv && ld_seg == 3'd1) |=> !ill_fault); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !out_vld && !lim_fault && $stable(lin_addr)); // R10
endmodule

bind seg_addr_unit seg_addr_unit_chk #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_priv(ld_priv), .ld_seg(ld_seg),
  .acc_valid(acc_valid), .acc_kind(acc_kind), .mode(mode), .offset(offset),
  .out_vld(out_vld), .lin_addr(lin_addr), .out_seg(out_seg),
  .lim_fault(lim_fault), .ill_fault(ill_fault)
);

// File: tb/seg_addr_unit_test.sv
`timescale 1ns/1ps
module seg_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en, ld_priv;
  logic [2:0]  ld_seg;
  logic [15:0] ld_sel;
  logic [63:0] ld_base;
  logic [31:0] ld_limit;
  logic        acc_valid, ovr_valid;
  logic [1:0]  acc_kind, mode;
  logic [2:0]  ovr_seg;
  logic [63:0] offset;
  logic        out_vld, lim_fault, ill_fault;
  logic [63:0] lin_addr;
  logic [2:0]  out_seg;

  always #2.5 clk = ~clk;

  seg_addr_unit uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_priv(ld_priv), .ld_seg(ld_seg),
    .ld_sel(ld_sel), .ld_base(ld_base), .ld_limit(ld_limit),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .ovr_valid(ovr_valid),
    .ovr_seg(ovr_seg), .mode(mode), .offset(offset),
    .out_vld(out_vld), .lin_addr(lin_addr), .out_seg(out_seg),
    .lim_fault(lim_fault), .ill_fault(ill_fault)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_sel  [6];
  logic [63:0] m_base [6];
  logic [31:0] m_lim  [6];
  logic [63:0] e_lin;
  logic [2:0]  e_seg;
  bit          e_vld, e_lim, e_ill;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] pick_seg();
    if (acc_kind == 2'd0) return 3'd1;
    if (ovr_valid && ovr_seg < 3'd6) return ovr_seg;
    case (acc_kind)
      2'd1:    return 3'd2;
      2'd2:    return 3'd0;
      default: return 3'd3;
    endcase
  endfunction

  task automatic tick(string tag);
    logic [2:0]  s;
    logic [63:0] a;
    bit          f;
    s = pick_seg();
    f = 0;
    if (mode == 2'd0) begin
      a = ((64'(m_sel[s]) * 16) + 64'(offset[15:0])) % 64'h10_0000;
    end else if (mode == 2'd1) begin
      a = (m_base[s] + offset) & 64'hFFFF_FFFF;
      f = offset[31:0] > m_lim[s];
    end else begin
      a = (s == 3'd4 || s == 3'd5) ? m_base[s] + offset : offset;
    end
    e_vld = acc_valid;
    e_lim = acc_valid && f;
    if (acc_valid) begin
      e_lin = a;
      e_seg = s;
    end
    e_ill = ld_en && !ld_priv && ld_seg == 3'd1;
    if (ld_en && ld_seg < 3'd6 && (ld_seg != 3'd1 || ld_priv)) begin
      m_sel[ld_seg]  = ld_sel;
      m_base[ld_seg] = ld_base;
      m_lim[ld_seg]  = ld_limit;
    end
    @(negedge clk);
    chk(tag, "out_vld", 64'(out_vld), 64'(e_vld));
    chk(tag, "lin_addr", lin_addr, e_lin);
    chk(tag, "lim_fault", 64'(lim_fault), 64'(e_lim));
    chk(tag, "ill_fault", 64'(ill_fault), 64'(e_ill));
    if (e_vld) chk(tag, "out_seg", 64'(out_seg), 64'(e_seg));
  endtask

  task automatic load(string tag, logic [2:0] s, logic [15:0] sel, logic [63:0] b,
                      logic [31:0] l, bit priv);
    ld_en = 1; ld_priv = priv; ld_seg = s; ld_sel = sel; ld_base = b; ld_limit = l;
    tick(tag);
    ld_en = 0; ld_priv = 0;
  endtask

  task automatic acc(string tag, logic [1:0] md, logic [1:0] k, bit ov,
                     logic [2:0] os, logic [63:0] ofs);
    acc_valid = 1; mode = md; acc_kind = k; ovr_valid = ov; ovr_seg = os; offset = ofs;
    tick(tag);
    acc_valid = 0; ovr_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ld_en = 0; ld_priv = 0; ld_seg = 0; ld_sel = 0; ld_base = 0; ld_limit = 0;
    acc_valid = 0; acc_kind = 0; ovr_valid = 0; ovr_seg = 0; mode = 0; offset = 0;
    for (int i = 0; i < 6; i++) begin
      m_sel[i] = 0; m_base[i] = 0; m_lim[i] = 32'h0000_FFFF;
    end
    e_lin = 0; e_seg = 0; e_vld = 0; e_lim = 0; e_ill = 0;
    repeat (3) @(negedge clk);
    chk("R1", "out_vld in reset", 64'(out_vld), 0);
    chk("R1", "lin_addr in reset", lin_addr, 0);
    chk("R1", "faults in reset", 64'({lim_fault, ill_fault}), 0);
    rst_n = 1;
    repeat (4) tick("R1");

    // reset contents: selector 0, limit 0xFFFF
    acc("R1", 2'd0, 2'd0, 0, 0, 64'h10);
    acc("R1", 2'd1, 2'd3, 0, 0, 64'hFFFF);
    acc("R1", 2'd1, 2'd3, 0, 0, 64'h1_0000);

    load("R9", 3'd0, 16'h1000, 64'h10_0000, 32'h0FFF, 0);
    load("R9", 3'd1, 16'hF000, 64'hFFFF_0000, 32'hFFFF_FFFF, 1);
    load("R9", 3'd2, 16'h2000, 64'h2_0000, 32'h7FFF, 0);
    load("R9", 3'd3, 16'h3000, 64'h3_0000, 32'hFFFF, 0);
    load("R9", 3'd4, 16'h4000, 64'h7000_0000_0000, 32'h10, 0);
    load("R9", 3'd5, 16'h5000, 64'hFFFF_FFFF_FFFF_F000, 32'h10, 0);
    load("R9", 3'd1, 16'h1234, 64'h55, 32'h1, 0);  // refused
    load("R9", 3'd7, 16'h9999, 64'h99, 32'h9, 1);  // no such segment
    acc("R9", 2'd0, 2'd0, 0, 0, 64'hFFF0);         // CS still 0xF000

    acc("R3", 2'd0, 2'd1, 0, 0, 64'h10);
    acc("R3", 2'd0, 2'd2, 0, 0, 64'h10);
    acc("R3", 2'd0, 2'd3, 0, 0, 64'h10);

    acc("R2", 2'd0, 2'd0, 1, 3'd2, 64'h8);
    acc("R2", 2'd1, 2'd0, 1, 3'd4, 64'h20);
    acc("R4", 2'd0, 2'd3, 1, 3'd4, 64'h30);
    acc("R4", 2'd1, 2'd1, 1, 3'd0, 64'h40);
    acc("R4", 2'd0, 2'd3, 1, 3'd7, 64'h50);
    acc("R4", 2'd0, 2'd2, 1, 3'd6, 64'h60);

    acc("R5", 2'd0, 2'd3, 0, 0, 64'h1234_0005);
    load("R5", 3'd3, 16'hFFFF, 64'h3_0000, 32'hFFFF, 0);
    acc("R5", 2'd0, 2'd3, 0, 0, 64'hFFFF);
    acc("R5", 2'd0, 2'd3, 0, 0, 64'hFFFF_FFFF);

    acc("R6", 2'd1, 2'd3, 0, 0, 64'h100);
    acc("R6", 2'd1, 2'd0, 0, 0, 64'h20);
    acc("R6", 2'd1, 2'd0, 0, 0, 64'hABCD_0000_0001_0000);

    acc("R7", 2'd1, 2'd1, 0, 0, 64'h7FFF);
    acc("R7", 2'd1, 2'd1, 0, 0, 64'h8000);
    acc("R7", 2'd1, 2'd2, 0, 0, 64'h1000);
    acc("R7", 2'd1, 2'd2, 0, 0, 64'h0FFF);

    acc("R8", 2'd2, 2'd3, 0, 0, 64'h1234_5678_9ABC_DEF0);
    acc("R8", 2'd2, 2'd3, 1, 3'd4, 64'h10);
    acc("R8", 2'd3, 2'd1, 1, 3'd5, 64'h2000);
    acc("R8", 2'd2, 2'd0, 0, 0, 64'hFFFF_0000_0000_0000);
    acc("R8", 2'd2, 2'd1, 0, 0, 64'hFFFF_FFFF);

    tick("R10");
    tick("R10");

    // load and access to DS in one cycle: old base expected
    ld_en = 1; ld_priv = 0; ld_seg = 3'd3; ld_sel = 16'h0400;
    ld_base = 64'h8000_0000; ld_limit = 32'hFFFF;
    acc("R11", 2'd1, 2'd3, 0, 0, 64'h4);
    ld_en = 0;
    acc("R11", 2'd1, 2'd3, 0, 0, 64'h4);
    acc("R11", 2'd0, 2'd3, 0, 0, 64'h4);

    // refused CS load alongside a fetch
    ld_en = 1; ld_priv = 0; ld_seg = 3'd1; ld_sel = 16'h0001;
    acc("R9", 2'd0, 2'd0, 0, 0, 64'h0);
    ld_en = 0;
    acc("R9", 2'd0, 2'd0, 0, 0, 64'h0);
    tick("R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule